// File: doc/BRIEF.md
# Pipelined Iteration-Domain Port Selector

This block walks a two-dimensional loop nest (outer index `i`, inner index `j`) one point at a time. At every point it computes, for each port, a small sum of the indices plus a constant and compares that sum with a threshold. The per-port results form a select word that steers a read multiplexer or a write demultiplexer further down the datapath. All loop bounds, offsets, thresholds and comparison directions are fixed when the block is built.

To keep every combinational path down to one operator, a single register sits between the adders and the comparators. Points are issued back to back, so once the register is full one select word leaves the block per clock. A ready input lets the consumer stall the walk. When the walk stalls, the counters and the register hold, and no point is lost or repeated. A pulse on `start_i` restarts the walk from point (0,0) at any time. `done_o` reports that the select word of the final point has been accepted.

Top module: `port_sel_seq`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o`, `done_o` and every bit of `sel_o` are 0 until a start is given.
- R2: After a start, the points are visited in row-major order with `j` stepping fastest from 0 to J_CNT-1 and `i` from 0 to I_CNT-1. Each of the I_CNT*J_CNT points is delivered exactly once.
- R3: For port p, bit p of `sel_o` is 1 when S = (USE_I[p] ? i : 0) + (USE_J[p] ? j : 0) + OFS[p] satisfies S >= THR[p] (when GE[p] = 1) or S < THR[p] (when GE[p] = 0). OFS and THR are packed CW bits per port, with port p at bits p*CW upward.
- R4: `valid_o` is 0 in the cycle after `start_i` is sampled. It is 1 in the cycle after that, carrying point (0,0).
- R5: With `ready_i` held at 1, a new select word appears every clock, with no gap, until the last point.
- R6: While `valid_o` is 1 and `ready_i` is 0 (and no start), `valid_o` and `sel_o` keep their values into the next cycle.
- R7: `done_o` rises in the cycle after the last point's word is taken (`valid_o` and `ready_i` both 1). It stays at 1 with `valid_o` at 0 until the next start, which clears it.
- R8: A start during a walk discards the word in flight and restarts from point (0,0).
- R9: `sel_o` is all zeros whenever `valid_o` is 0.
- R10: A one-dimensional build (I_CNT = 1, J_CNT = 10) with two ports set to j < 5 and j >= 5 produces the select strings 1111100000 and 0000011111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Restart the walk from point (0,0) |
| ready_i | input | 1 | Consumer accepts the current select word |
| sel_o | output | N_PORTS | Per-port select word for the current point |
| valid_o | output | 1 | `sel_o` holds a point's result |
| done_o | output | 1 | Last point's word has been accepted |

## Verification
A start sampled at one clock edge gives an empty output in the next cycle and point (0,0) in the cycle after that. The bench checks both of these samples right after the start pulse, at falling edges. Each later word counts as taken at the rising edge that follows a falling-edge sample showing `valid_o` and `ready_i` both high. The scoreboard pops its expected word at that same sample. The stall hold and the rise of `done_o` are therefore checked one falling edge after the sample that caused them, and the `done_o` check is skipped while a start is pending.

// File: rtl/port_sel_pkg.sv
package port_sel_pkg;

    // Comparison directions for a port expression.
    typedef enum logic {
        CMP_LT = 1'b0,
        CMP_GE = 1'b1
    } cmp_kind_e;

    localparam int unsigned CMP_W = 16;

    function automatic logic cmp_eval(input cmp_kind_e kind,
                                      input logic [CMP_W-1:0] lhs,
                                      input logic [CMP_W-1:0] rhs);
        logic res;
        if (kind == CMP_GE) res = (lhs >= rhs);
        else                res = (lhs <  rhs);
        return res;
    endfunction

endpackage

// File: rtl/iter_walk.sv
module iter_walk #(
    parameter int unsigned I_CNT = 4,
    parameter int unsigned J_CNT = 5,
    parameter int unsigned IW    = 2,
    parameter int unsigned JW    = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          step_i,
    output logic [IW-1:0] i_o,
    output logic [JW-1:0] j_o,
    output logic          last_o
);
    localparam logic [IW-1:0] I_LAST = IW'(I_CNT - 1);
    localparam logic [JW-1:0] J_LAST = JW'(J_CNT - 1);

    typedef struct packed {
        logic [IW-1:0] i;
        logic [JW-1:0] j;
    } walk_t;

    walk_t st_d, st_q;
    logic  at_last;

    assign at_last = (st_q.i == I_LAST) && (st_q.j == J_LAST);

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (step_i) begin
            if (st_q.j == J_LAST) begin
                st_d.j = '0;
                st_d.i = (st_q.i == I_LAST) ? '0 : st_q.i + 1'b1;
            end else begin
                st_d.j = st_q.j + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign i_o    = st_q.i;
    assign j_o    = st_q.j;
    assign last_o = at_last;

    // R2: indices never leave the domain
    assert_in_domain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(i_o) < I_CNT) && (int'(j_o) < J_CNT));

    // R2: stepping from the final point returns to the origin
    assert_wrap_origin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clear_i && last_o) |=> (i_o == '0 && j_o == '0));

endmodule

// File: rtl/sel_eval_pipe.sv
module sel_eval_pipe
    import port_sel_pkg::*;
#(
    parameter int unsigned          N_PORTS = 3,
    parameter int unsigned          IW      = 2,
    parameter int unsigned          JW      = 3,
    parameter int unsigned          CW      = 8,
    parameter logic [N_PORTS-1:0]   USE_I   = '1,
    parameter logic [N_PORTS-1:0]   USE_J   = '1,
    parameter logic [N_PORTS-1:0]   GE      = '0,
    parameter logic [N_PORTS*CW-1:0] OFS    = '0,
    parameter logic [N_PORTS*CW-1:0] THR    = '0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               flush_i,
    input  logic               load_i,
    input  logic               in_valid_i,
    input  logic               in_last_i,
    input  logic [IW-1:0]      i_i,
    input  logic [JW-1:0]      j_i,
    output logic [N_PORTS-1:0] sel_o,
    output logic               valid_o,
    output logic               last_o
);
    localparam int unsigned SW = CW + 2;

    typedef struct packed {
        logic                          valid;
        logic                          last;
        logic [N_PORTS-1:0][SW-1:0]    sum;
    } pipe_t;

    pipe_t st_d, st_q;
    logic [N_PORTS-1:0][SW-1:0] sum_now;

    // Adder half: one sum per port from the current point.
    always_comb begin
        for (int p = 0; p < N_PORTS; p++) begin
            sum_now[p] = (USE_I[p] ? SW'(i_i) : '0)
                       + (USE_J[p] ? SW'(j_i) : '0)
                       + SW'(OFS[p*CW +: CW]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.valid = 1'b0;
            st_d.last  = 1'b0;
        end else if (load_i) begin
            st_d.valid = in_valid_i;
            st_d.last  = in_valid_i & in_last_i;
            st_d.sum   = sum_now;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // Comparator half: one comparison per port from the registered sum.
    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_cmp
            logic hit;
            assign hit = cmp_eval(GE[p] ? CMP_GE : CMP_LT,
                                  CMP_W'(st_q.sum[p]),
                                  CMP_W'(THR[p*CW +: CW]));
            assign sel_o[p] = st_q.valid & hit;
        end
    endgenerate

    assign valid_o = st_q.valid;
    assign last_o  = st_q.last;

    // R8: a flush empties the stage
    assert_flush_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !valid_o);

    // R9: the stage presents no selection while empty
    assert_idle_no_sel_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> (sel_o == '0));

endmodule

// File: rtl/port_sel_seq.sv
module port_sel_seq #(
    parameter int unsigned            I_CNT   = 4,
    parameter int unsigned            J_CNT   = 5,
    parameter int unsigned            N_PORTS = 3,
    parameter int unsigned            CW      = 8,
    parameter logic [N_PORTS-1:0]     USE_I   = 3'b101,
    parameter logic [N_PORTS-1:0]     USE_J   = 3'b011,
    parameter logic [N_PORTS-1:0]     GE      = 3'b110,
    parameter logic [N_PORTS*CW-1:0]  OFS     = {8'd2, 8'd1, 8'd0},
    parameter logic [N_PORTS*CW-1:0]  THR     = {8'd4, 8'd4, 8'd4}
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               ready_i,
    output logic [N_PORTS-1:0] sel_o,
    output logic               valid_o,
    output logic               done_o
);
    localparam int unsigned IW = (I_CNT > 1) ? $clog2(I_CNT) : 1;
    localparam int unsigned JW = (J_CNT > 1) ? $clog2(J_CNT) : 1;

    typedef struct packed {
        logic running;
        logic done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IW-1:0] cur_i;
    logic [JW-1:0] cur_j;
    logic          walk_last;
    logic          pipe_valid;
    logic          pipe_last;
    logic          advance;
    logic          step;
    logic          take;

    assign advance = !pipe_valid || ready_i;
    assign step    = ctl_q.running && advance && !start_i;
    assign take    = pipe_valid && ready_i && !start_i;

    iter_walk #(
        .I_CNT (I_CNT),
        .J_CNT (J_CNT),
        .IW    (IW),
        .JW    (JW)
    ) u_walk (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (start_i),
        .step_i  (step),
        .i_o     (cur_i),
        .j_o     (cur_j),
        .last_o  (walk_last)
    );

    sel_eval_pipe #(
        .N_PORTS (N_PORTS),
        .IW      (IW),
        .JW      (JW),
        .CW      (CW),
        .USE_I   (USE_I),
        .USE_J   (USE_J),
        .GE      (GE),
        .OFS     (OFS),
        .THR     (THR)
    ) u_pipe (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .flush_i    (start_i),
        .load_i     (advance),
        .in_valid_i (ctl_q.running),
        .in_last_i  (walk_last),
        .i_i        (cur_i),
        .j_i        (cur_j),
        .sel_o      (sel_o),
        .valid_o    (pipe_valid),
        .last_o     (pipe_last)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (start_i) begin
            ctl_d.running = 1'b1;
            ctl_d.done    = 1'b0;
        end else begin
            if (step && walk_last) ctl_d.running = 1'b0;
            if (take && pipe_last) ctl_d.done    = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign valid_o = pipe_valid;
    assign done_o  = ctl_q.done;

    // R4: nothing is presented in the cycle after a start
    assert_start_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> !valid_o);

    // R5: a non-final word that is taken is followed at once by the next
    assert_no_bubble_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && ready_i && !start_i && !pipe_last) |=> valid_o);

    // R6: a stalled word is held
    assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !ready_i && !start_i) |=> (valid_o && $stable(sel_o)));

    // R7: once finished, the output stays empty
    assert_done_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !valid_o);

    // R7: finishing follows acceptance of the final word
    assert_done_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(valid_o && ready_i));

endmodule

// File: tb/port_sel_seq_test.sv
module port_sel_seq_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NI = 4;
    localparam int  NJ = 5;
    localparam int  NL = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ready = 1'b0;
    logic [2:0] sel_a;
    logic [1:0] sel_b;
    logic val_a, val_b, done_a, done_b;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [2:0] q_a[$];
    logic [1:0] q_b[$];
    bit due_a = 1'b0, due_b = 1'b0;
    bit stall_a = 1'b0, stall_b = 1'b0;
    logic [2:0] held_a;
    logic [1:0] held_b;
    logic [9:0] str_p0, str_p1;
    int nb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_sel_seq uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ready_i(ready),
        .sel_o(sel_a), .valid_o(val_a), .done_o(done_a));

    port_sel_seq #(
        .I_CNT(1), .J_CNT(NL), .N_PORTS(2), .CW(8),
        .USE_I(2'b00), .USE_J(2'b11), .GE(2'b10),
        .OFS({8'd0, 8'd0}), .THR({8'd5, 8'd5})
    ) uut_line (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ready_i(ready),
        .sel_o(sel_b), .valid_o(val_b), .done_o(done_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // R3 reference for the default build: {i+2>=4, j+1>=4, i+j<4}
    function automatic logic [2:0] ref_a(input int i, input int j);
        return {(i + 2) >= 4, (j + 1) >= 4, (i + j) < 4};
    endfunction

    // R10 reference for the line build: {j>=5, j<5}
    function automatic logic [1:0] ref_b(input int j);
        return {j >= 5, j < 5};
    endfunction

    // Driver: pulse start and load both scoreboards with the full walk (R2 order).
    task automatic start_run();
        @(posedge clk); #1;
        ready = 1'b0;
        start = 1'b1;
        q_a.delete(); q_b.delete();
        due_a = 1'b0; due_b = 1'b0;
        nb = 0;
        for (int i = 0; i < NI; i++)
            for (int j = 0; j < NJ; j++)
                q_a.push_back(ref_a(i, j));
        for (int j = 0; j < NL; j++) q_b.push_back(ref_b(j));
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        check(val_a == 1'b0, "R4 empty after start", int'(val_a), 0);
        check(val_b == 1'b0, "R4 empty after start line", int'(val_b), 0);
        @(negedge clk);
        check(val_a == 1'b1, "R4 first word due", int'(val_a), 1);
        check(val_b == 1'b1, "R4 first word due line", int'(val_b), 1);
    endtask

    task automatic drain(input int mode);
        int k = 0;
        logic [7:0] lf = 8'h5a;
        while ((q_a.size() != 0 || q_b.size() != 0) && k < 2000) begin
            @(posedge clk); #1;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            ready = (mode == 0) ? 1'b1 : lf[0];
            k++;
        end
        @(posedge clk); #1;
        ready = 1'b1;
        check(k < 2000, "R2 walk completes", k, 0);
    endtask

    // Monitor for the two-dimensional build.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!val_a) check(sel_a == 3'b000, "R9 idle select", int'(sel_a), 0);
            if (stall_a && !start) begin
                check(val_a == 1'b1, "R6 stalled valid held", int'(val_a), 1);
                check(sel_a == held_a, "R6 stalled select held", int'(sel_a), int'(held_a));
            end
            if (!start && due_a) begin
                check(done_a == 1'b1, "R7 done after last", int'(done_a), 1);
                check(val_a == 1'b0, "R7 idle when done", int'(val_a), 0);
            end
            if (!start && q_a.size() != 0)
                check(done_a == 1'b0, "R7 done low while walking", int'(done_a), 0);
            stall_a = val_a && !ready && !start;
            held_a = sel_a;
            if (val_a && ready && !start) begin
                if (q_a.size() == 0) begin
                    check(1'b0, "R2 extra word", int'(sel_a), -1);
                end else begin
                    logic [2:0] e;
                    e = q_a.pop_front();
                    check(sel_a == e, "R3 select word", int'(sel_a), int'(e));
                    if (q_a.size() == 0) due_a = 1'b1;
                end
            end
        end
    end

    // Monitor for the one-dimensional build.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!val_b) check(sel_b == 2'b00, "R9 idle select line", int'(sel_b), 0);
            if (stall_b && !start)
                check(val_b && sel_b == held_b, "R6 line held", int'(sel_b), int'(held_b));
            if (!start && due_b)
                check(done_b == 1'b1, "R7 done after last line", int'(done_b), 1);
            stall_b = val_b && !ready && !start;
            held_b = sel_b;
            if (val_b && ready && !start) begin
                if (q_b.size() == 0) begin
                    check(1'b0, "R10 extra word", int'(sel_b), -1);
                end else begin
                    logic [1:0] e;
                    e = q_b.pop_front();
                    check(sel_b == e, "R10 line select", int'(sel_b), int'(e));
                    if (nb < NL) begin
                        str_p0[NL-1-nb] = sel_b[0];
                        str_p1[NL-1-nb] = sel_b[1];
                    end
                    nb++;
                    if (q_b.size() == 0) due_b = 1'b1;
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1'b1;
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(val_a == 0 && done_a == 0 && sel_a == 0, "R1 in reset", int'(sel_a), 0);
        check(val_b == 0 && done_b == 0 && sel_b == 0, "R1 in reset line", int'(sel_b), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(val_a == 0 && done_a == 0, "R1 after reset", int'(val_a), 0);
        check(val_b == 0 && done_b == 0, "R1 after reset line", int'(val_b), 0);

        // Run 1: ready held high, R5 one word per clock
        start_run();
        ready = 1'b1;
        for (int c = 0; c < NI * NJ - 1; c++) begin
            @(negedge clk);
            check(val_a == 1'b1, "R5 no gap", int'(val_a), 1);
        end
        drain(0);
        repeat (3) @(negedge clk);
        check(done_a == 1'b1 && val_a == 1'b0, "R7 done persists", int'(done_a), 1);
        check(str_p0 == 10'b1111100000, "R10 port0 string", int'(str_p0), 10'b1111100000);
        check(str_p1 == 10'b0000011111, "R10 port1 string", int'(str_p1), 10'b0000011111);

        // Run 2: irregular stalls, R6 and R2 under backpressure
        start_run();
        drain(1);
        repeat (3) @(negedge clk);
        check(done_a == 1'b1, "R7 done after stalled run", int'(done_a), 1);

        // Run 3: restart in the middle of a walk (R8)
        start_run();
        @(posedge clk); #1;
        ready = 1'b1;
        repeat (6) @(posedge clk);
        start_run();
        check(q_a.size() == NI * NJ, "R8 restart from origin", q_a.size(), NI * NJ);
        drain(1);
        repeat (3) @(negedge clk);
        check(done_a == 1'b1 && done_b == 1'b1, "R8 restarted walk finishes", int'(done_a), 1);

        finished = 1'b1;
        summary();
    end
endmodule